// File: doc/BRIEF.md
# Interpolating Root-Raised-Cosine I/Q Filter

This block sits between a sample buffer and a dual-channel DAC. It accepts complex baseband samples at one quarter of its clock rate and produces one shaped sample per clock on each of the I and Q rails. The coefficient set is loaded by the host before the filter runs. It describes a root raised cosine pulse that has been multiplied by an x/sin(x) term, so that the filter also cancels the amplitude droop of the DAC's zero-order hold. Raising the rate from the symbol-side sample rate to the DAC clock moves the images far from the band. This lets the analogue reconstruction filter that follows be a simple one.

The filter is built as a four-phase polyphase structure with 49 taps in total, so each phase has 13 taps. Both rails share one coefficient store and one phase sequencer, and each rail has its own delay line and multiply-accumulate tree. The sum is kept at full precision, rounded and shifted once, and then clamped to the 14-bit DAC range. When the upstream buffer has nothing to offer at an input slot, a zero enters the delay line and the output rate stays the same.

Top module: `iq_interp_fir`

## Requirements
- R1: Synchronous reset (`rst` high) clears the output strobe, both output words and both delay lines. After reset, a running filter that receives no samples outputs zero on every strobe.
- R2: `inReady` is high only when `run` is high, `rst` is low and the internal phase counter is 0. While `run` stays high it is high on exactly one clock in every four, and it is never high on two clocks in a row.
- R3: `outValid` follows `run` with a two-clock lag. It is high on every clock whose value of `run` two clocks earlier was high and whose value of `run` one clock earlier was also high.
- R4: A sample accepted at a clock edge (inValid and inReady both high) enters the delay line as the newest entry x[0]. The next four strobes carry phases 0, 1, 2 and 3 in that order. Phase p is sum over k=0..12 of h[4k+p]·x[k], where x[k] is the sample accepted k input slots earlier, and any tap index above 48 counts as zero.
- R5: At an input slot (inReady high) with `inValid` low, a zero enters the delay line in place of a sample.
- R6: The full-precision sum is rounded to nearest with ties toward positive infinity. This is done by adding 2^16 and then shifting right arithmetically by 17 bits.
- R7: A rounded result above 8191 outputs 8191, and one below -8192 outputs -8192, as 14-bit two's complement.
- R8: A coefficient write (`coefWe` high, `coefAddr` below 49, 16-bit signed `coefData`) stores tap `coefAddr` only on a clock where `rst` is high or `run` is low. While the filter runs, a write has no effect. Coefficients survive reset.
- R9: The I and Q rails use the same coefficients and carry independent data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High to run the filter; low to hold it idle |
| inValid | input | 1 | Upstream sample present |
| inReady | output | 1 | Sample taken on this clock |
| inI | input | 16 | I sample, signed |
| inQ | input | 16 | Q sample, signed |
| coefWe | input | 1 | Coefficient write enable |
| coefAddr | input | 6 | Tap index 0..48 |
| coefData | input | 16 | Tap value, signed |
| outValid | output | 1 | Output strobe |
| outI | output | 14 | I DAC word, signed |
| outQ | output | 14 | Q DAC word, signed |

## Verification
The bench loads a ramp of distinct tap values and sends a single impulse. With distinct taps, a design that selected the wrong taps for a phase, ran the phases out of order or failed to zero-stuff produces the wrong value at a known strobe. Exact half-LSB and just-past-half sums on both rails detect a floor or a round toward zero, because those produce 0 where 1 or -1 is expected. Full-scale inputs against all-maximum taps drive both rails past the limits, where a missing clamp would wrap around in sign. A tap write issued while running is then checked through the output, which would change if the write had been stored.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  localparam int INTERP = 4;
  localparam int PH_W   = $clog2(INTERP);

  typedef struct packed {
    logic            shift;
    logic            calc;
    logic [PH_W-1:0] phase;
  } iqf_ctl_t;
endpackage

// File: rtl/iqf_ctrl.sv
module iqf_ctrl
  import iqf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  output logic     inReady,
  output logic     outValid,
  output iqf_ctl_t ctl
);
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] calcPh;
  logic            calcQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= '0;
      calcPh   <= '0;
      calcQ    <= 1'b0;
      outValid <= 1'b0;
    end else begin
      ph       <= run ? ((ph == PH_W'(INTERP - 1)) ? '0 : ph + 1'b1) : '0;
      calcPh   <= ph;
      calcQ    <= run;
      outValid <= calcQ;
    end
  end

  assign inReady   = run && !rst && (ph == '0);
  assign ctl.shift = inReady;
  assign ctl.calc  = calcQ;
  assign ctl.phase = calcPh;
endmodule

// File: rtl/iqf_coef_bank.sv
module iqf_coef_bank
  import iqf_pkg::*;
#(
  parameter int NTAPS = 49,
  parameter int CW    = 16,
  parameter int AW    = 6,
  parameter int TPP   = 13
) (
  input  logic                    clk,
  input  logic                    wrOk,
  input  logic                    coefWe,
  input  logic [AW-1:0]           coefAddr,
  input  logic [CW-1:0]           coefData,
  input  logic [PH_W-1:0]         phase,
  output logic [TPP-1:0][CW-1:0]  taps
);
  logic [CW-1:0] mem [NTAPS];

  always_ff @(posedge clk) begin
    if (coefWe && wrOk && (int'(coefAddr) < NTAPS))
      mem[coefAddr] <= coefData;
  end

  always_comb begin
    for (int k = 0; k < TPP; k++) begin
      int idx;
      idx = k * INTERP + int'(phase);
      taps[k] = (idx < NTAPS) ? mem[idx] : '0;
    end
  end
endmodule

// File: rtl/iqf_rail.sv
module iqf_rail
  import iqf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 14,
  parameter int TPP   = 13,
  parameter int SHIFT = 17,
  parameter int ACCW  = 38
) (
  input  logic                   clk,
  input  logic                   rst,
  input  iqf_ctl_t               ctl,
  input  logic                   inValid,
  input  logic [DW-1:0]          sampleIn,
  input  logic [TPP-1:0][CW-1:0] taps,
  output logic [OW-1:0]          outWord
);
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((64'sd1 <<< (OW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -MAXV - 1;
  localparam logic signed [ACCW-1:0] HALF = ACCW'(64'sd1 <<< (SHIFT - 1));

  logic [TPP-1:0][DW-1:0]   line;
  logic signed [ACCW-1:0]   acc;
  logic signed [ACCW-1:0]   shr;
  logic signed [CW+DW-1:0]  prod;
  logic [OW-1:0]            satWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
    end else if (ctl.shift) begin
      line[0] <= inValid ? sampleIn : '0;
      for (int k = 1; k < TPP; k++) line[k] <= line[k-1];
    end
  end

  always_comb begin
    acc  = '0;
    prod = '0;
    for (int k = 0; k < TPP; k++) begin
      prod = $signed(line[k]) * $signed(taps[k]);
      acc  = acc + ACCW'(prod);
    end
    shr = (acc + HALF) >>> SHIFT;
    if (shr > MAXV)      satWord = MAXV[OW-1:0];
    else if (shr < MINV) satWord = MINV[OW-1:0];
    else                 satWord = shr[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)           outWord <= '0;
    else if (ctl.calc) outWord <= satWord;
  end
endmodule

// File: rtl/iq_interp_fir.sv
module iq_interp_fir
  import iqf_pkg::*;
#(
  parameter int NTAPS = 49,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 14,
  parameter int SHIFT = 17
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [DW-1:0]             inI,
  input  logic [DW-1:0]             inQ,
  input  logic                      coefWe,
  input  logic [$clog2(NTAPS)-1:0]  coefAddr,
  input  logic [CW-1:0]             coefData,
  output logic                      outValid,
  output logic [OW-1:0]             outI,
  output logic [OW-1:0]             outQ
);
  localparam int TPP  = (NTAPS + INTERP - 1) / INTERP;
  localparam int AW   = $clog2(NTAPS);
  localparam int ACCW = CW + DW + 6;

  iqf_ctl_t              ctl;
  logic [TPP-1:0][CW-1:0] taps;
  logic [1:0][DW-1:0]    railIn;
  logic [1:0][OW-1:0]    railOut;

  iqf_ctrl u_ctrl (
    .clk(clk), .rst(rst), .run(run),
    .inReady(inReady), .outValid(outValid), .ctl(ctl)
  );

  iqf_coef_bank #(.NTAPS(NTAPS), .CW(CW), .AW(AW), .TPP(TPP)) u_coef (
    .clk(clk), .wrOk(rst || !run), .coefWe(coefWe), .coefAddr(coefAddr),
    .coefData(coefData), .phase(ctl.phase), .taps(taps)
  );

  assign railIn[0] = inI;
  assign railIn[1] = inQ;

  for (genvar r = 0; r < 2; r++) begin : g_rail
    iqf_rail #(.DW(DW), .CW(CW), .OW(OW), .TPP(TPP), .SHIFT(SHIFT), .ACCW(ACCW)) u_rail (
      .clk(clk), .rst(rst), .ctl(ctl), .inValid(inValid),
      .sampleIn(railIn[r]), .taps(taps), .outWord(railOut[r])
    );
  end

  assign outI = railOut[0];
  assign outQ = railOut[1];
endmodule

// File: rtl/iqf_checker.sv
module iqf_checker #(
  parameter int OW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          inReady,
  input logic          outValid,
  input logic [OW-1:0] outI,
  input logic [OW-1:0] outQ
);
  // R1: the clock after reset shows a quiet output
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && outI == '0 && outQ == '0));

  // R2: input slots are never back to back
  a_r2_ready_gap: assert property (@(posedge clk) disable iff (rst)
    inReady |=> !inReady);

  // R2: input slots recur every four clocks while running
  a_r2_ready_period: assert property (@(posedge clk) disable iff (rst)
    ($past(inReady, 4) && $past(run, 3) && $past(run, 2) && $past(run) && run) |-> inReady);

  // R3: a strobe implies run two clocks earlier
  a_r3_strobe_lag: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(run, 2));

  // R3: sustained run gives a strobe
  a_r3_strobe_steady: assert property (@(posedge clk) disable iff (rst)
    ($past(run, 2) && $past(run) && !$past(rst, 2) && !$past(rst)) |-> outValid);
endmodule

bind iq_interp_fir iqf_checker #(.OW(OW)) u_iqf_checker (
  .clk(clk), .rst(rst), .run(run), .inReady(inReady),
  .outValid(outValid), .outI(outI), .outQ(outQ)
);

// File: tb/test_iq_interp_fir.sv
module test_iq_interp_fir;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              run = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic signed [15:0] inI = '0;
  logic signed [15:0] inQ = '0;
  logic              coefWe = 1'b0;
  logic [5:0]        coefAddr = '0;
  logic signed [15:0] coefData = '0;
  logic              outValid;
  logic signed [13:0] outI;
  logic signed [13:0] outQ;

  int total = 0;
  int bad   = 0;
  string phaseTag = "R1";

  iq_interp_fir i_iq_interp_fir (
    .clk(clk), .rst(rst), .run(run), .inValid(inValid), .inReady(inReady),
    .inI(inI), .inQ(inQ), .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  int     h [49];
  longint histI [$];
  longint histQ [$];
  int     mPh = 0;
  bit     mCalc = 0;
  bit     pendOk = 0;
  int     pendI = 0, pendQ = 0;
  bit     expV = 0;
  int     expI = 0, expQ = 0;

  function automatic int quant(longint s);
    longint r;
    r = (s + 65536) >>> 17;
    if (r > 8191)  r = 8191;
    if (r < -8192) r = -8192;
    return int'(r);
  endfunction

  function automatic longint phaseSum(longint hist[$], int p);
    longint s = 0;
    for (int k = 0; k < 13; k++) begin
      int idx = 4 * k + p;
      if (idx < 49) s += longint'(h[idx]) * hist[k];
    end
    return s;
  endfunction

  initial begin
    for (int i = 0; i < 13; i++) begin histI.push_back(0); histQ.push_back(0); end
  end

  always @(posedge clk) begin
    if (rst) begin
      foreach (histI[k]) begin histI[k] = 0; histQ[k] = 0; end
      mPh = 0; mCalc = 0; expV = 0; expI = 0; expQ = 0; pendI = 0; pendQ = 0;
    end else begin
      expV = mCalc;
      if (mCalc) begin expI = pendI; expQ = pendQ; end
      if (run && mPh == 0) begin
        histI.push_front(inValid ? longint'(inI) : 0); void'(histI.pop_back());
        histQ.push_front(inValid ? longint'(inQ) : 0); void'(histQ.pop_back());
      end
    end
    if (coefWe && (rst || !run) && coefAddr < 49) h[coefAddr] = int'(coefData);
    if (!rst) begin
      pendI = quant(phaseSum(histI, mPh));
      pendQ = quant(phaseSum(histQ, mPh));
      mCalc = run;
      mPh   = run ? (mPh + 1) % 4 : 0;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // every-clock comparison
  always @(negedge clk) begin
    if (!rst) begin
      check({"R2 inReady ", phaseTag}, inReady, (run && mPh == 0));
      check({"R3 outValid ", phaseTag}, outValid, expV);
      if (expV) begin
        check({phaseTag, " outI"}, outI, expI);
        check({phaseTag, " outQ"}, outQ, expQ);
      end
    end
  end

  task automatic writeCoef(int a, int v);
    @(negedge clk);
    coefWe = 1; coefAddr = 6'(a); coefData = 16'(v);
    @(negedge clk);
    coefWe = 0;
  endtask

  task automatic sendGrab(int xi, int xq, output int gi, output int gq);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1; inI = 16'(xi); inQ = 16'(xq);
    @(posedge clk);
    @(negedge clk);
    inValid = 0;
    @(posedge clk);
    @(negedge clk);
    gi = outI; gq = outQ;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1; run = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int gi, gq, rc, vc;
    // R8: coefficients loaded while held in reset, ramp 100..4900
    for (int i = 0; i < 49; i++) writeCoef(i, (i + 1) * 100);
    @(negedge clk);
    check("R1 reset outValid", outValid, 0);
    check("R1 reset outI", outI, 0);
    check("R1 reset outQ", outQ, 0);
    rst = 0; run = 1;
    phaseTag = "R1";
    repeat (24) @(negedge clk);

    // R2 / R3 counting over a window
    rc = 0; vc = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      rc += inReady; vc += outValid;
    end
    check("R2 ready count in 40", rc, 10);
    check("R3 strobe count in 40", vc, 40);

    // R4 / R5: impulse then zero stuffing
    phaseTag = "R4";
    sendGrab(8192, -8192, gi, gq);
    check("R4 phase0 I", gi, 6);
    check("R4 phase0 Q", gq, -6);
    phaseTag = "R5";
    repeat (60) @(negedge clk);

    // R3: stop and restart
    phaseTag = "R3";
    run = 0;
    repeat (6) @(negedge clk);
    check("R3 idle strobe", outValid, 0);
    run = 1;
    repeat (12) @(negedge clk);

    // R6 / R9: rounding on both rails with only tap 0 set to 4
    phaseTag = "R6";
    doReset();
    for (int i = 0; i < 49; i++) writeCoef(i, (i == 0) ? 4 : 0);
    run = 1;
    sendGrab(16384, -16385, gi, gq);
    check("R6 half rounds up I", gi, 1);
    check("R9 Q below half rounds to -1", gq, -1);
    sendGrab(16383, -16384, gi, gq);
    check("R6 below half I", gi, 0);
    check("R6 negative half Q", gq, 0);

    // R8: write while running has no effect
    phaseTag = "R8";
    writeCoef(0, 0);
    sendGrab(16384, 16384, gi, gq);
    check("R8 running write ignored I", gi, 1);
    check("R8 running write ignored Q", gq, 1);

    // R7: saturation
    phaseTag = "R7";
    doReset();
    for (int i = 0; i < 49; i++) writeCoef(i, 32767);
    run = 1;
    for (int n = 0; n < 14; n++) sendGrab(32767, -32768, gi, gq);
    check("R7 clamp high", gi, 8191);
    check("R7 clamp low", gq, -8192);
    repeat (20) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule